// File: doc/BRIEF.md
# Instruction Address Compare Unit

This block watches the instruction fetch stream and tells the debug logic which of its compare registers each fetched address hits. It holds a set of programmable compare registers, grouped two by two into pairs. In exact mode, each register of a pair is an independent compare value. In bit-match mode, the second register of the pair becomes a bit mask for the first. That lets a single pair cover any address pattern where some bits are fixed and the rest are free. Address bit 0 takes no part in any comparison, on either side.

Each fetch enters on a valid/ready handshake. One registered result leaves on a second valid/ready handshake. The result carries one match flag per compare register, and the debug event logic raises an instruction-address event from each set flag.

Back-pressure rules:
- A result stays on the outputs, unchanged, until the consumer takes it with `res_ready`.
- A new fetch is accepted only when the output stage is empty, or when it is being emptied in the same cycle.
- Nothing is dropped or reordered.

Register writes, per-register enables and per-pair mode selects are plain control pins.

Top module: `iac_unit`

## Requirements
- R1: After reset, `res_valid` is 0 and `fetch_ready` is 1.
- R2: In exact mode, bit k of `res_match` is set when register k is enabled and bits ADDR_W-1..1 of the fetch address equal the same bits of register k. Bit k of `res_match` belongs to register k.
- R3: Bit 0 of the fetch address and bit 0 of every compare register never affect any match flag.
- R4: A match flag is never set for a disabled register. `cmp_enable[k]`=0 disables register k. In bit-match mode, the enable of the first register of the pair governs that pair's match.
- R5: `pair_mode[p]`=1 selects bit-match mode for pair p, and 0 selects exact mode. In bit-match mode, register 2p+1 is the mask for register 2p: a mask bit of 1 compares that address bit and a mask bit of 0 ignores it. The enable of the mask register plays no part.
- R6: While pair p is in bit-match mode, flag 2p+1 is always 0.
- R7: The mode of one pair has no effect on the flags of the other pair.
- R8: A write through `reg_wr_en`/`reg_wr_idx`/`reg_wr_data` updates register `reg_wr_idx` at the clock edge. A fetch accepted at that same edge is compared against the old value, and fetches accepted at later edges use the new value.
- R9: Every accepted fetch produces exactly one result, in order. The result appears on the outputs in the cycle after acceptance, and its flags may all be 0.
- R10: While `res_valid`=1 and `res_ready`=0, `res_match` holds steady and `fetch_ready` is 0. `fetch_ready` is 1 whenever the output stage is empty or is being drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch address is valid |
| fetch_ready | output | 1 | Unit can accept a fetch |
| fetch_addr | input | ADDR_W | Fetched instruction address |
| reg_wr_en | input | 1 | Compare register write strobe |
| reg_wr_idx | input | IDX_W | Register written (0..NUM_REGS-1) |
| reg_wr_data | input | ADDR_W | Value written |
| cmp_enable | input | NUM_REGS | Per-register enable |
| pair_mode | input | NUM_PAIRS | Per-pair mode: 1 bit-match, 0 exact |
| res_valid | output | 1 | Result is valid |
| res_ready | input | 1 | Consumer takes the result |
| res_match | output | NUM_REGS | Per-register match flags |

## Verification
The bench builds the unit with its defaults: 32-bit addresses and two pairs, which gives four registers. With two pairs, one pair can sit in bit-match mode while the other stays in exact mode, so cross-pair independence becomes checkable. The full 32-bit width lets masks that leave the upper address bits free, or that leave every bit free, be tried against addresses far apart. A stuttering consumer pattern then fills the single output stage and holds it. This shows that results stay in order and steady while stalled.

// File: rtl/iac_pkg.sv
package iac_pkg;
  typedef enum logic {
    IAC_MODE_EXACT    = 1'b0,
    IAC_MODE_BITMATCH = 1'b1
  } iac_mode_e;

  localparam int IAC_DEF_ADDR_W    = 32;
  localparam int IAC_DEF_NUM_PAIRS = 2;
endpackage

// File: rtl/iac_regfile.sv
module iac_regfile #(
  parameter int ADDR_W   = 32,
  parameter int NUM_REGS = 4,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [ADDR_W-1:0]                wr_data,
  output logic [NUM_REGS-1:0][ADDR_W-1:0]  regs
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(k));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs[k] <= '0;
      end else if (hit) begin
        regs[k] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/iac_pair_cmp.sv
module iac_pair_cmp
  import iac_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] reg_lo,
  input  logic [ADDR_W-1:0] reg_hi,
  input  logic              en_lo,
  input  logic              en_hi,
  input  iac_mode_e         mode,
  output logic [1:0]        hit
);
  localparam logic [ADDR_W-1:0] CARE_MASK = {{(ADDR_W-1){1'b1}}, 1'b0};

  logic [ADDR_W-1:0] diff_lo;
  logic [ADDR_W-1:0] diff_hi;
  logic              exact_lo;
  logic              exact_hi;
  logic              masked_lo;

  assign diff_lo   = (addr ^ reg_lo) & CARE_MASK;
  assign diff_hi   = (addr ^ reg_hi) & CARE_MASK;
  assign exact_lo  = (diff_lo == '0);
  assign exact_hi  = (diff_hi == '0);
  assign masked_lo = ((diff_lo & reg_hi) == '0);

  always_comb begin
    unique case (mode)
      IAC_MODE_BITMATCH: begin
        hit[0] = en_lo && masked_lo;
        hit[1] = 1'b0;
      end
      default: begin
        hit[0] = en_lo && exact_lo;
        hit[1] = en_hi && exact_hi;
      end
    endcase
  end
endmodule

// File: rtl/iac_out_stage.sv
module iac_out_stage #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/iac_unit.sv
module iac_unit
  import iac_pkg::*;
#(
  parameter int ADDR_W    = IAC_DEF_ADDR_W,
  parameter int NUM_PAIRS = IAC_DEF_NUM_PAIRS,
  localparam int NUM_REGS = 2 * NUM_PAIRS,
  localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fetch_valid,
  output logic                 fetch_ready,
  input  logic [ADDR_W-1:0]    fetch_addr,
  input  logic                 reg_wr_en,
  input  logic [IDX_W-1:0]     reg_wr_idx,
  input  logic [ADDR_W-1:0]    reg_wr_data,
  input  logic [NUM_REGS-1:0]  cmp_enable,
  input  logic [NUM_PAIRS-1:0] pair_mode,
  output logic                 res_valid,
  input  logic                 res_ready,
  output logic [NUM_REGS-1:0]  res_match
);
  logic [NUM_REGS-1:0][ADDR_W-1:0] cmp_regs;
  logic [NUM_REGS-1:0]             hit_now;

  iac_regfile #(
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS)
  ) u_regfile (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .wr_idx  (reg_wr_idx),
    .wr_data (reg_wr_data),
    .regs    (cmp_regs)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    iac_pair_cmp #(
      .ADDR_W (ADDR_W)
    ) u_cmp (
      .addr   (fetch_addr),
      .reg_lo (cmp_regs[2*p]),
      .reg_hi (cmp_regs[2*p+1]),
      .en_lo  (cmp_enable[2*p]),
      .en_hi  (cmp_enable[2*p+1]),
      .mode   (iac_mode_e'(pair_mode[p])),
      .hit    (hit_now[2*p+1 -: 2])
    );
  end

  iac_out_stage #(
    .WIDTH (NUM_REGS)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (fetch_valid),
    .in_ready  (fetch_ready),
    .in_data   (hit_now),
    .out_valid (res_valid),
    .out_ready (res_ready),
    .out_data  (res_match)
  );
endmodule

// File: rtl/iac_unit_chk.sv
module iac_unit_chk #(
  parameter int NUM_REGS  = 4,
  parameter int NUM_PAIRS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 fetch_valid,
  input logic                 fetch_ready,
  input logic [NUM_REGS-1:0]  cmp_enable,
  input logic [NUM_PAIRS-1:0] pair_mode,
  input logic                 res_valid,
  input logic                 res_ready,
  input logic [NUM_REGS-1:0]  res_match
);
  logic accept;
  assign accept = fetch_valid && fetch_ready;

  // R9
  result_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> res_valid);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_match)));

  // R10
  stall_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |-> !fetch_ready);

  // R10
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> fetch_ready);

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_en
    if (k % 2 == 0) begin : g_lo
      // R4
      disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !cmp_enable[k]) |=> !res_match[k]);
    end else begin : g_hi
      // R4
      disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !cmp_enable[k] && !pair_mode[k/2]) |=> !res_match[k]);
    end
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_mode
    // R6
    mask_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && pair_mode[p]) |=> !res_match[2*p+1]);
  end
endmodule

bind iac_unit iac_unit_chk #(
  .NUM_REGS  (NUM_REGS),
  .NUM_PAIRS (NUM_PAIRS)
) u_iac_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fetch_valid (fetch_valid),
  .fetch_ready (fetch_ready),
  .cmp_enable  (cmp_enable),
  .pair_mode   (pair_mode),
  .res_valid   (res_valid),
  .res_ready   (res_ready),
  .res_match   (res_match)
);

// File: tb/iac_unit_bench.sv
module iac_unit_bench;
  localparam int AW = 32;
  localparam int NP = 2;
  localparam int NR = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fetch_valid = 1'b0;
  logic          fetch_ready;
  logic [AW-1:0] fetch_addr = '0;
  logic          reg_wr_en = 1'b0;
  logic [1:0]    reg_wr_idx = '0;
  logic [AW-1:0] reg_wr_data = '0;
  logic [NR-1:0] cmp_enable = '0;
  logic [NP-1:0] pair_mode = '0;
  logic          res_valid;
  logic          res_ready = 1'b1;
  logic [NR-1:0] res_match;

  always #10 clk = ~clk;

  iac_unit u_iac_unit (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_addr(fetch_addr), .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx),
    .reg_wr_data(reg_wr_data), .cmp_enable(cmp_enable), .pair_mode(pair_mode),
    .res_valid(res_valid), .res_ready(res_ready), .res_match(res_match)
  );

  int checks = 0;
  int errors = 0;
  logic [NR-1:0] exp_q[$];
  string         tag_q[$];
  logic [AW-1:0] m_reg [NR];
  bit            bp_on = 1'b0;
  int            bp_cnt = 0;
  bit            was_stalled = 1'b0;
  logic [NR-1:0] held;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NR-1:0] model(input logic [AW-1:0] a);
    logic [NR-1:0] r;
    logic [AW-1:0] care;
    care = ~AW'(1);
    for (int p = 0; p < NP; p++) begin
      if (pair_mode[p]) begin
        r[2*p]   = cmp_enable[2*p] && ((((a ^ m_reg[2*p]) & m_reg[2*p+1]) & care) == '0);
        r[2*p+1] = 1'b0;
      end else begin
        r[2*p]   = cmp_enable[2*p]   && (((a ^ m_reg[2*p])   & care) == '0);
        r[2*p+1] = cmp_enable[2*p+1] && (((a ^ m_reg[2*p+1]) & care) == '0);
      end
    end
    return r;
  endfunction

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input int idx, input logic [AW-1:0] d);
    reg_wr_en = 1'b1; reg_wr_idx = 2'(idx); reg_wr_data = d;
    step();
    reg_wr_en = 1'b0;
    m_reg[idx] = d;
  endtask

  task automatic fetch(input logic [AW-1:0] a, input string tag);
    bit acc;
    fetch_valid = 1'b1; fetch_addr = a;
    do begin
      @(negedge clk);
      acc = fetch_ready;
      step();
    end while (!acc);
    exp_q.push_back(model(a));
    tag_q.push_back(tag);
    fetch_valid = 1'b0;
  endtask

  // R8: write and fetch share one edge; the fetch sees the old value
  task automatic wr_and_fetch(input int idx, input logic [AW-1:0] d, input logic [AW-1:0] a);
    logic [NR-1:0] e;
    e = model(a);
    reg_wr_en = 1'b1; reg_wr_idx = 2'(idx); reg_wr_data = d;
    fetch_valid = 1'b1; fetch_addr = a;
    step();
    reg_wr_en = 1'b0; fetch_valid = 1'b0;
    exp_q.push_back(e);
    tag_q.push_back("R8");
    m_reg[idx] = d;
  endtask

  always @(posedge clk) begin
    #2;
    bp_cnt++;
    res_ready = bp_on ? ((bp_cnt % 3) == 0) : 1'b1;
  end

  // Monitor: pops expected items as results leave
  always @(negedge clk) begin
    if (rst_n) begin
      if (was_stalled && res_valid)
        check(res_match == held, "R10 hold", 32'(res_match), 32'(held));
      if (res_valid && !res_ready)
        check(!fetch_ready, "R10 ready", 32'(fetch_ready), 32'd0);
      was_stalled = res_valid && !res_ready;
      held = res_match;
      if (res_valid && res_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 extra result", 32'(res_match), 32'd0);
        end else begin
          logic [NR-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(res_match == e, t, 32'(res_match), 32'(e));
        end
      end
    end
  end

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < NR; k++) m_reg[k] = '0;
    repeat (3) step();
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(res_valid == 1'b0, "R1 res_valid", 32'(res_valid), 32'd0);
    check(fetch_ready == 1'b1, "R1 fetch_ready", 32'(fetch_ready), 32'd1);
    step();

    wr(0, 32'h1000_0000);
    wr(1, 32'h2000_0004);
    wr(2, 32'h3000_0100);
    wr(3, 32'h4000_0200);
    cmp_enable = 4'hF; pair_mode = 2'b00;
    fetch(32'h1000_0000, "R2 reg0");
    fetch(32'h2000_0004, "R2 reg1");
    fetch(32'h3000_0100, "R2 reg2");
    fetch(32'h1234_5678, "R2 none");
    fetch(32'h1000_0001, "R3 addr lsb");
    fetch(32'h4000_0201, "R3 addr lsb reg3");
    wr(2, 32'h3000_0101);
    fetch(32'h3000_0100, "R3 reg lsb");

    cmp_enable = 4'hE;
    fetch(32'h1000_0000, "R4 disabled reg0");
    cmp_enable = 4'hF;

    pair_mode = 2'b01;
    wr(0, 32'h0000_1230);
    wr(1, 32'h0000_FFF0);
    fetch(32'h0000_1234, "R5 low bits free");
    fetch(32'hABCD_1235, "R5 high bits free");
    fetch(32'h0000_1330, "R5 masked miss");
    fetch(32'h0000_FFF0, "R6 mask silent");
    fetch(32'h3000_0100, "R7 pair1 exact");
    cmp_enable = 4'hD;
    fetch(32'h0000_1234, "R5 mask enable unused");
    cmp_enable = 4'hE;
    fetch(32'h0000_1234, "R4 bitmatch disabled");
    cmp_enable = 4'hF;
    wr(1, 32'h0000_0001);
    fetch(32'hFFFF_FFFE, "R5 empty mask");

    pair_mode = 2'b10;
    wr(3, 32'hFF00_0000);
    wr(2, 32'h5500_0000);
    fetch(32'h55AB_CDEF, "R5 pair1 bitmatch");
    fetch(32'hFF00_0000, "R6 pair1 mask silent");
    fetch(32'h0000_1230, "R7 pair0 exact");

    pair_mode = 2'b00;
    wr_and_fetch(0, 32'h0000_8000, 32'h0000_1230);
    fetch(32'h0000_8000, "R8 new value");
    fetch(32'h0000_1230, "R8 old value gone");

    repeat (4) step();
    bp_on = 1'b1;
    for (int i = 0; i < 12; i++) begin
      fetch((i % 2 == 0) ? 32'h0000_8000 : 32'h3000_0100 + 32'(i), "R9 stream");
    end
    repeat (10) step();
    bp_on = 1'b0;
    repeat (4) step();

    check(exp_q.size() == 0, "R9 all delivered", 32'(exp_q.size()), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule